// File: doc/BRIEF.md
# Byte-Wide DAC Code Loader with Output Override

This block sits between an 8-bit processor bus and a 12-bit current-output converter. A 12-bit code is built from two byte writes into a holding (input) register and then moved into the converter-facing DAC register. Four active-low strobes decide each transfer: a write strobe, a high-byte select, a low-byte select and a load strobe. A byte write can land in the holding register alone, or in the holding register and the DAC register in the same cycle. A load with neither byte selected copies the holding register across. A common sequence is three writes: the high byte, then the low byte, then a load.

A format/override input and a control input share one decode. While the format/override input is high, control picks how bytes map onto the 12-bit code: left-justified (control 0) or right-justified (control 1). While it is low, the output code is forced to all zeros (control 0) or all ones (control 1). The DAC register underneath keeps its contents, and its value returns once the override is released. All strobes are synchronous to `clk`. Every rising edge on which the write strobe is low performs the decoded action.

Top module: `bytewise_dac_loader`

## Requirements
- R1: An active-low reset clears the holding and DAC registers to zero, so `code_out` reads 0x000 after reset with the override released.
- R2: While `wr_n` is high, neither register changes, whatever the other strobes and data are.
- R3: `wr_n`=0, `hi_sel_n`=1, `lo_sel_n`=0, `ldac_n`=1 writes the low byte into the holding register only; `code_out` does not change.
- R4: `wr_n`=0, `hi_sel_n`=1, `lo_sel_n`=0, `ldac_n`=0 writes the low byte and updates the DAC register in the same edge. The DAC register receives the holding value that already contains the new byte.
- R5: `wr_n`=0, `hi_sel_n`=0, `lo_sel_n`=1 writes the high byte into the holding register. The DAC register is updated with the merged value in the same edge only when `ldac_n`=0.
- R6: `wr_n`=0 with both selects high and `ldac_n`=0 copies the holding register into the DAC register. With `ldac_n`=1 in that state, nothing happens.
- R7: `wr_n`=0 with both selects low performs no transfer, whatever `ldac_n` is.
- R8: With `fmt_ovr_n`=0, `code_out` is 0x000 when `ctrl`=0 and 0xFFF when `ctrl`=1, without delay. The DAC register keeps its value, and `code_out` shows it again as soon as `fmt_ovr_n` returns high.
- R9: Left-justified placement (`fmt_ovr_n`=1, `ctrl`=0): a high-byte write fills code bits 11..4 from `din`[7:0]. A low-byte write fills code bits 3..0 from `din`[7:4], and `din`[3:0] is ignored.
- R10: Right-justified placement (`fmt_ovr_n`=1, `ctrl`=1): a high-byte write fills code bits 11..8 from `din`[3:0], and `din`[7:4] is ignored. A low-byte write fills code bits 7..0 from `din`.
- R11: While `fmt_ovr_n`=0, byte writes use left-justified placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of both registers |
| wr_n | input | 1 | Active-low write strobe |
| hi_sel_n | input | 1 | Active-low high-byte select |
| lo_sel_n | input | 1 | Active-low low-byte select |
| ldac_n | input | 1 | Active-low DAC register load |
| fmt_ovr_n | input | 1 | High: format select through `ctrl`; low: output override through `ctrl` |
| ctrl | input | 1 | Justification choice or forced level |
| din | input | 8 | Bus data byte |
| code_out | output | 12 | Code presented to the converter |

## Verification
The bench sweeps all 4096 codes in both justifications through the three-write sequence. Junk in the ignored nibbles would show up at the output if a design mapped the wrong bits. It applies all sixteen strobe combinations from a state where the holding and DAC registers differ, and then reads the holding register out with a load. A decoder that acted on both selects low, or that ignored the load strobe during a byte write, would leave the wrong value behind. A design that loaded the DAC register with the old holding value during a combined byte-and-load write would show the stale code. The override checks confirm that the forced levels leave the DAC register intact, and that writes during an override use left placement.

// File: rtl/dac_ldr_pkg.sv
package dac_ldr_pkg;
  typedef struct packed {
    logic take_hi;
    logic take_lo;
    logic push;
  } ldr_act_t;

  typedef enum logic {
    JUST_LEFT  = 1'b0,
    JUST_RIGHT = 1'b1
  } just_t;
endpackage

// File: rtl/ldr_decode.sv
module ldr_decode
  import dac_ldr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_n,
  input  logic     hi_sel_n,
  input  logic     lo_sel_n,
  input  logic     ldac_n,
  output ldr_act_t act
);
  always_comb begin
    act = '0;
    if (!wr_n) begin
      unique case ({hi_sel_n, lo_sel_n})
        2'b10:   begin act.take_lo = 1'b1; act.push = !ldac_n; end
        2'b01:   begin act.take_hi = 1'b1; act.push = !ldac_n; end
        2'b11:   act.push = !ldac_n;
        default: act = '0;
      endcase
    end
  end

  AST_ONE_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.take_hi && act.take_lo)); // R7
endmodule

// File: rtl/ldr_hold_reg.sv
module ldr_hold_reg
  import dac_ldr_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ldr_act_t          act,
  input  just_t             just,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] in_next
);
  localparam int HI_W = CODE_W - BUS_W;

  function automatic logic [CODE_W-1:0] merge_byte(
    input logic [CODE_W-1:0] cur,
    input logic [BUS_W-1:0]  d,
    input logic              hi,
    input logic              right);
    logic [CODE_W-1:0] r;
    r = cur;
    if (hi) begin
      if (right) r[CODE_W-1 -: HI_W]  = d[HI_W-1:0];
      else       r[CODE_W-1 -: BUS_W] = d;
    end else begin
      if (right) r[BUS_W-1:0] = d;
      else       r[HI_W-1:0]  = d[BUS_W-1 -: HI_W];
    end
    return r;
  endfunction

  always_comb begin
    in_next = in_q;
    if (act.take_hi || act.take_lo)
      in_next = merge_byte(in_q, din, act.take_hi, just == JUST_RIGHT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= in_next;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.take_hi || act.take_lo) |=> $stable(in_q)); // R2
  AST_HI_KEEPS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    act.take_hi |=> in_q[HI_W-1:0] == $past(in_q[HI_W-1:0])); // R9
endmodule

// File: rtl/ldr_dac_reg.sv
module ldr_dac_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CODE_W-1:0] in_next,
  input  logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] dac_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dac_q <= '0;
    else if (push) dac_q <= in_next;
  end

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(dac_q)); // R3
  AST_DAC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> dac_q == in_q); // R4
endmodule

// File: rtl/ldr_out_sel.sv
module ldr_out_sel #(
  parameter int CODE_W = 12
) (
  input  logic              fmt_ovr_n,
  input  logic              ctrl,
  input  logic [CODE_W-1:0] dac_q,
  output logic [CODE_W-1:0] code_out
);
  always_comb code_out = fmt_ovr_n ? dac_q : {CODE_W{ctrl}};
endmodule

// File: rtl/bytewise_dac_loader.sv
module bytewise_dac_loader
  import dac_ldr_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              hi_sel_n,
  input  logic              lo_sel_n,
  input  logic              ldac_n,
  input  logic              fmt_ovr_n,
  input  logic              ctrl,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] code_out
);
  ldr_act_t          act;
  just_t             just;
  logic [CODE_W-1:0] in_q, in_next, dac_q;

  always_comb just = (fmt_ovr_n && ctrl) ? JUST_RIGHT : JUST_LEFT;

  ldr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hi_sel_n(hi_sel_n),
    .lo_sel_n(lo_sel_n), .ldac_n(ldac_n), .act(act));

  ldr_hold_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .act(act), .just(just), .din(din),
    .in_q(in_q), .in_next(in_next));

  ldr_dac_reg #(.CODE_W(CODE_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .push(act.push), .in_next(in_next),
    .in_q(in_q), .dac_q(dac_q));

  ldr_out_sel #(.CODE_W(CODE_W)) u_sel (
    .fmt_ovr_n(fmt_ovr_n), .ctrl(ctrl), .dac_q(dac_q), .code_out(code_out));

  AST_WR_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(dac_q) && $stable(in_q)); // R2
  AST_BOTH_SEL_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !hi_sel_n && !lo_sel_n) |=> $stable(dac_q) && $stable(in_q)); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_ovr_n |-> code_out == dac_q); // R8
  AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_ovr_n |-> code_out == {CODE_W{ctrl}}); // R8
endmodule

// File: tb/bytewise_dac_loader_bench.sv
module bytewise_dac_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, hi_sel_n = 1'b1, lo_sel_n = 1'b1, ldac_n = 1'b1;
  logic fmt_ovr_n = 1'b1, ctrl = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [11:0] code_out;
  int checks = 0, fails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  bytewise_dac_loader u_bytewise_dac_loader (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hi_sel_n(hi_sel_n),
    .lo_sel_n(lo_sel_n), .ldac_n(ldac_n), .fmt_ovr_n(fmt_ovr_n),
    .ctrl(ctrl), .din(din), .code_out(code_out));

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (code_out !== exp) begin
      fails++;
      $display("FAIL %s: code_out=%03h expected=%03h", req, code_out, exp);
    end
  endtask

  // one bus cycle: strobes driven at a falling edge, released at the next
  task automatic bus(input logic w, input logic hs, input logic ls,
                     input logic ld, input logic [7:0] d);
    @(negedge clk);
    wr_n = w; hi_sel_n = hs; lo_sel_n = ls; ldac_n = ld; din = d;
    @(negedge clk);
    wr_n = 1'b1; hi_sel_n = 1'b1; lo_sel_n = 1'b1; ldac_n = 1'b1; din = 8'h00;
    #1;
  endtask

  task automatic load_left(input logic [11:0] c);
    bus(0, 0, 1, 1, c[11:4]);
    bus(0, 1, 0, 1, {c[3:0], ~c[7:4]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset value", 12'h000);
    rst_n = 1'b1;

    // R9 and R10: full three-write sweep in both formats
    for (int j = 0; j < 2; j++) begin
      ctrl = j[0];
      for (int c = 0; c < 4096; c++) begin
        logic [11:0] code = c[11:0];
        if (j == 0) begin
          bus(0, 0, 1, 1, code[11:4]);
          bus(0, 1, 0, 1, {code[3:0], code[11:8] ^ 4'h9});
        end else begin
          bus(0, 0, 1, 1, {code[7:4] ^ 4'h6, code[11:8]});
          bus(0, 1, 0, 1, code[7:0]);
        end
        bus(0, 1, 1, 0, 8'hFF);
        check(j == 0 ? "R9 left placement" : "R10 right placement", code);
      end
    end
    ctrl = 1'b0;

    // Strobe truth table: holding y, DAC x, data d (left format)
    for (int k = 0; k < 16; k++) begin
      logic [11:0] x = 12'h3A5, y = 12'hC3E, inx, dx;
      logic [7:0]  d = 8'h5C;
      logic w = k[3], hs = k[2], ls = k[1], ld = k[0];
      load_left(x);
      bus(0, 1, 1, 0, 8'h00);
      load_left(y);
      inx = y; dx = x;
      if (!w) begin
        if (hs && !ls)      inx = {y[11:4], d[7:4]};
        else if (!hs && ls) inx = {d, y[3:0]};
        if ((hs ^ ls) || (hs && ls)) if (!ld) dx = inx;
      end
      bus(w, hs, ls, ld, d);
      if (w)                    check("R2 wr_n high keeps DAC", dx);
      else if (!hs && !ls)      check("R7 both selects low keeps DAC", dx);
      else if (hs && !ls)       check(ld ? "R3 low byte only" : "R4 low byte with load", dx);
      else if (!hs && ls)       check("R5 high byte load choice", dx);
      else                      check("R6 plain load", dx);
      bus(0, 1, 1, 0, 8'h00);
      if (w)               check("R2 wr_n high keeps holding reg", inx);
      else if (!hs && !ls) check("R7 both selects low keeps holding reg", inx);
      else                 check("R6 holding reg readout", inx);
    end

    // R8 override and release
    load_left(12'h6D2);
    bus(0, 1, 1, 0, 8'h00);
    fmt_ovr_n = 1'b0; ctrl = 1'b0; #1;
    check("R8 forced zeros", 12'h000);
    ctrl = 1'b1; #1;
    check("R8 forced ones", 12'hFFF);
    fmt_ovr_n = 1'b1; ctrl = 1'b0; #1;
    check("R8 value restored", 12'h6D2);

    // R11 writes during override use left placement
    fmt_ovr_n = 1'b0; ctrl = 1'b1;
    bus(0, 0, 1, 0, 8'hB7);
    check("R11 output still forced", 12'hFFF);
    fmt_ovr_n = 1'b1; ctrl = 1'b0; #1;
    check("R11 left placement under override", 12'hB72);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 reset clears DAC", 12'h000);
    @(negedge clk); rst_n = 1'b1;
    bus(0, 1, 1, 0, 8'h00);
    check("R1 reset clears holding reg", 12'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule